// File: doc/BRIEF.md
# Write-Started Watchdog Timer

This block is a watchdog built from a clock prescaler and a period down-counter. After reset both stages are frozen and the interrupt output stays low. Nothing runs until software first writes the start/refresh register, shown here as a one-cycle write strobe. That first write arms the block for good. From then on, only a reset can stop it.

While the block runs, the prescaler emits one tick every `PRESCALE_DIV` clocks, and each tick decrements the down-counter. The counter starts at `PERIOD_TICKS`. When it would pass zero, the block raises a one-clock interrupt request and reloads the full period by itself, so the interrupt repeats until software refreshes the counter.

A refresh write reloads the down-counter only. The prescaler keeps its phase, because only reset clears it. Software has to refresh more often than once per full period to keep the interrupt from firing.

Top module: `armed_watchdog`

## Requirements
- R1: After reset `wdt_irq` is 0, and it stays 0 for any number of cycles in which `refresh_we` is never asserted, because the prescaler and the counter are both frozen.
- R2: The first cycle with `refresh_we` high starts the block. Counting that strobe's clock edge as edge 0, `wdt_irq` is first high in the cycle after edge `PRESCALE_DIV*PERIOD_TICKS`.
- R3: `wdt_irq` is never high for two consecutive cycles.
- R4: After an interrupt the counter reloads the full period, so while no refresh occurs, interrupts follow at exactly `PRESCALE_DIV*PERIOD_TICKS`-cycle spacing.
- R5: A refresh strobe at edge r (relative to the start edge) reloads the counter to `PERIOD_TICKS` and leaves the prescaler phase alone. The next interrupt appears after edge `PRESCALE_DIV*(floor(r/PRESCALE_DIV)+PERIOD_TICKS)`, and there is none before it.
- R6: A refresh strobe on the same edge at which the counter would expire suppresses that interrupt. The cycle after any refresh edge has `wdt_irq` low.
- R7: Once started, the block keeps counting until reset. A reset returns it to the stopped state with the prescaler cleared, so the timing of R2 applies again from the next start write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_we | input | 1 | One-cycle write strobe of the start/refresh register |
| wdt_irq | output | 1 | One-clock watchdog interrupt request |

## Verification
The embedded assertions check, on every cycle, the properties that hold at all times. The interrupt is never longer than one cycle. A refresh always leaves the next cycle free of interrupts and reloads the counter. The block never stops once armed, and the prescaler stays frozen while the block is stopped. Exact interrupt positions need the scenarios in the bench. These are the first expiry after a start write, the delay a mid-period refresh adds given the retained prescaler phase, the periodic repetition, and the restart timing after a reset in mid-run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Operating state of the watchdog: frozen until armed by a write.
    typedef enum logic {
        WDT_STOPPED = 1'b0,
        WDT_RUNNING = 1'b1
    } wdt_state_e;

    // Events delivered to the period counter in a given cycle.
    typedef struct packed {
        logic refresh;  // software write to the start/refresh register
        logic tick;     // prescaler terminal count
    } wdt_evt_t;

    // Width needed to hold values 0..max_val.
    function automatic int unsigned wdt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/wdt_run_ctrl.sv
module wdt_run_ctrl
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       refresh_i,
    output wdt_state_e state_o
);

    wdt_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WDT_STOPPED;
        end else if (refresh_i) begin
            state_q <= WDT_RUNNING;
        end
    end

    assign state_o = state_q;

    // Once armed, only reset may stop the watchdog.
    assert_run_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == WDT_RUNNING) |=> (state_q == WDT_RUNNING));

    // A write always leaves the block armed.
    assert_write_arms_R2: assert property (@(posedge clk) disable iff (rst)
        refresh_i |=> (state_q == WDT_RUNNING));

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int unsigned DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic tick_o
);

    generate
        if (DIV <= 1) begin : g_bypass
            assign tick_o = en_i;
        end else begin : g_divide
            localparam int unsigned PW   = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);

            logic [PW-1:0] phase_q;

            // Cleared only by reset; refresh writes never touch it.
            always_ff @(posedge clk) begin
                if (rst) begin
                    phase_q <= '0;
                end else if (en_i) begin
                    if (phase_q == LAST) begin
                        phase_q <= '0;
                    end else begin
                        phase_q <= phase_q + 1'b1;
                    end
                end
            end

            assign tick_o = en_i && (phase_q == LAST);

            // Frozen while the watchdog is stopped.
            assert_prescaler_frozen_R1: assert property (@(posedge clk) disable iff (rst)
                !en_i |=> $stable(phase_q));

            // Phase never leaves its legal range.
            assert_prescaler_range_R5: assert property (@(posedge clk) disable iff (rst)
                phase_q <= LAST);
        end
    endgenerate

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter
    import wdt_pkg::*;
#(
    parameter int unsigned PERIOD = 256
) (
    input  logic     clk,
    input  logic     rst,
    input  wdt_evt_t evt_i,
    output logic     irq_o
);

    localparam int unsigned CW = wdt_width(PERIOD);
    localparam logic [CW-1:0] RELOAD = CW'(PERIOD);

    logic [CW-1:0] remain_q;
    logic          irq_q;
    logic          expire;

    assign expire = evt_i.tick && (remain_q <= CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= RELOAD;
            irq_q    <= 1'b0;
        end else if (evt_i.refresh) begin
            // Refresh wins over a coincident expiry.
            remain_q <= RELOAD;
            irq_q    <= 1'b0;
        end else if (expire) begin
            remain_q <= RELOAD;
            irq_q    <= 1'b1;
        end else begin
            if (evt_i.tick) begin
                remain_q <= remain_q - 1'b1;
            end
            irq_q <= 1'b0;
        end
    end

    assign irq_o = irq_q;

    assert_irq_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);

    assert_reload_on_irq_R4: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (remain_q == RELOAD));

    assert_refresh_reload_R5: assert property (@(posedge clk) disable iff (rst)
        evt_i.refresh |=> (remain_q == RELOAD));

    assert_refresh_wins_R6: assert property (@(posedge clk) disable iff (rst)
        evt_i.refresh |=> !irq_q);

    assert_no_tick_no_irq_R1: assert property (@(posedge clk) disable iff (rst)
        !evt_i.tick |=> !irq_q);

endmodule

// File: rtl/armed_watchdog.sv
module armed_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned PRESCALE_DIV = 16,
    parameter int unsigned PERIOD_TICKS = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic refresh_we,
    output logic wdt_irq
);

    wdt_state_e state;
    logic       running;
    logic       tick;
    wdt_evt_t   evt;

    wdt_run_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .refresh_i (refresh_we),
        .state_o   (state)
    );

    assign running = (state == WDT_RUNNING);

    wdt_prescaler #(
        .DIV (PRESCALE_DIV)
    ) u_prescaler (
        .clk    (clk),
        .rst    (rst),
        .en_i   (running),
        .tick_o (tick)
    );

    assign evt.refresh = refresh_we;
    assign evt.tick    = tick;

    wdt_down_counter #(
        .PERIOD (PERIOD_TICKS)
    ) u_counter (
        .clk   (clk),
        .rst   (rst),
        .evt_i (evt),
        .irq_o (wdt_irq)
    );

    // A stopped watchdog never requests an interrupt next cycle.
    assert_stopped_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !running |=> !wdt_irq);

endmodule

// File: tb/armed_watchdog_tb.sv
module armed_watchdog_tb;

    localparam int DIV = 4;
    localparam int PER = 5;
    localparam int FULL = DIV * PER;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic refresh_we = 1'b0;
    logic wdt_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    armed_watchdog #(
        .PRESCALE_DIV (DIV),
        .PERIOD_TICKS (PER)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .refresh_we (refresh_we),
        .wdt_irq    (wdt_irq)
    );

    // Vector table: refresh edge relative to start (-1 = none), expected irq edge.
    localparam int NV = 6;
    localparam int VREF [NV] = '{-1, 3, 4, 7, 10, 20};
    localparam int VEXP [NV] = '{20, 20, 24, 24, 28, 40};
    localparam string VTAG [NV] = '{"R2", "R5", "R5", "R5", "R5", "R6"};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock edge; inputs set before it, output sampled at the next negedge.
    task automatic step(input logic we, output logic irq);
        refresh_we = we;
        @(posedge clk);
        @(negedge clk);
        refresh_we = 1'b0;
        irq = wdt_irq;
    endtask

    task automatic do_reset();
        logic d;
        rst = 1'b1;
        repeat (3) step(1'b0, d);
        rst = 1'b0;
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog timeout: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic irq;
        int first;
        int count;

        @(negedge clk);
        do_reset();
        chk(wdt_irq == 1'b0, "R1 reset value", int'(wdt_irq), 0);

        // R1: no write, no interrupt
        count = 0;
        for (int i = 0; i < 200; i++) begin
            step(1'b0, irq);
            if (irq) count++;
        end
        chk(count == 0, "R1 idle without write", count, 0);

        // Vector table walk: R2, R5, R6
        for (int v = 0; v < NV; v++) begin
            do_reset();
            step(1'b1, irq);  // edge 0: start write
            first = -1;
            count = 0;
            for (int e = 1; e <= VEXP[v] + 1; e++) begin
                step(e == VREF[v], irq);
                if (irq) begin
                    count++;
                    if (first < 0) first = e;
                end
            end
            chk(first == VEXP[v], VTAG[v], first, VEXP[v]);
            chk(count == 1, "R3 single-cycle pulse", count, 1);
        end

        // R4: periodic re-arm without refresh
        do_reset();
        step(1'b1, irq);
        count = 0;
        for (int e = 1; e <= 3 * FULL + 1; e++) begin
            step(1'b0, irq);
            if (irq) begin
                count++;
                chk(e == count * FULL, "R4 periodic expiry edge", e, count * FULL);
            end
        end
        chk(count == 3, "R4 expiry count", count, 3);

        // R5: steady refreshing keeps it quiet; last refresh at 90 -> irq at 108
        do_reset();
        step(1'b1, irq);
        first = -1;
        for (int e = 1; e <= 109; e++) begin
            step((e % 15 == 0) && (e <= 90), irq);
            if (irq && first < 0) first = e;
        end
        chk(first == 108, "R5 repeated refresh", first, 108);

        // R7: reset mid-run stops it; restart timing from scratch
        do_reset();
        step(1'b1, irq);
        for (int e = 1; e <= 10; e++) step(1'b0, irq);
        do_reset();
        count = 0;
        for (int e = 0; e < 100; e++) begin
            step(1'b0, irq);
            if (irq) count++;
        end
        chk(count == 0, "R7 stopped after reset", count, 0);
        step(1'b1, irq);
        first = -1;
        for (int e = 1; e <= FULL + 1; e++) begin
            step(1'b0, irq);
            if (irq && first < 0) first = e;
        end
        chk(first == FULL, "R7 restart timing", first, FULL);

        // R7: keeps counting after first expiry (not stopped by interrupt)
        first = -1;
        for (int e = FULL + 2; e <= 2 * FULL + 1; e++) begin
            step(1'b0, irq);
            if (irq && first < 0) first = e;
        end
        chk(first == 2 * FULL, "R7 keeps running", first, 2 * FULL);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule